// File: doc/BRIEF.md
# Entropy Buffer Refill Sequencer

This block keeps a circular store of random words topped up from an entropy source. Each harvest arms the source with a chosen ring-oscillator selection and that selection's sampling ratio. The block waits for a completion pulse carrying a status code, then collects six words from the source one at a time over a request/acknowledge port. A consumer drains the store in arrival order through a valid/ready word port.

A harvest is started only when at least six slots are free. Only one harvest is in flight at a time. Some outcomes mean the current oscillator is unusable: a failed batch with an autocorrelation or watchdog cause, or a word read back as zero. In those cases the block moves up to the next oscillator that has a nonzero ratio, and gives up when none is left. A continuous-test error reported while strict mode is on halts the block for good.

Consumer port rules: `cons_valid` is high whenever the store holds a word and the block has not halted. `cons_data` shows the oldest word. A word leaves on a cycle where `cons_valid` and `cons_ready` are both high. While `cons_ready` stays low, `cons_valid` and `cons_data` hold unchanged. The only exception is a halt, which drops `cons_valid`.

Top module: `entropy_refill_seq`

## Requirements
- R1: During and directly after reset, `cons_valid`, `busy`, `fatal_err` and `src_start` are low. The first harvest is then started without any consumer action.
- R2: Words leave the consumer port in the exact order they were accepted. `cons_data` holds steady while `cons_valid` is high and `cons_ready` is low.
- R3: The store has 32 slots, with one slot always kept empty, so it holds at most 31 words. A harvest is armed only when at least 6 slots are free. With no consumer, an empty store fills to 30 words and then stops.
- R4: Each arming pulses `src_start` for one cycle. In that same cycle, `src_osc_sel` carries the oscillator index and `src_ratio` carries that oscillator's ratio, which is nonzero.
- R5: A new episode arms the lowest-numbered oscillator with a nonzero ratio. This is oscillator 0 whenever its ratio is nonzero.
- R6: Status bits are: bit0 data valid, bit1 autocorrelation error, bit2 watchdog timeout. A completion with bit0 clear and bit1 or bit2 set discards the batch without any word read. The block then re-arms the next higher oscillator with a nonzero ratio, provided 6 slots are free.
- R7: A completion with bit0 clear and neither bit1 nor bit2 set (a von Neumann fault only) is treated as good, and its six words are accepted.
- R8: A word read back as zero ends the batch. Words before it are kept, and the zero and all later words are dropped. The block then falls back as in R6.
- R9: When no higher usable oscillator remains, or fewer than 6 slots are free at fallback, the block goes idle. It restarts only after a consumer read that leaves at least 6 slots free.
- R10: After a good batch, the block re-arms the same oscillator at once if 6 slots are free; otherwise it goes idle with `busy` low.
- R11: At most one harvest is outstanding. A consumer read during a harvest starts no second one.
- R12: Status bit3 (continuous-test error) with `strict_mode` high raises `fatal_err` permanently. From then on there are no starts, no reads, and `cons_valid` is low. With `strict_mode` low, bit3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | Make continuous-test errors fatal |
| osc_ratio | input | 64 | Four 16-bit sampling ratios, oscillator 0 in the low bits |
| src_start | output | 1 | One-cycle arm pulse to the source |
| src_osc_sel | output | 2 | Oscillator index for the armed harvest |
| src_ratio | output | 16 | Sampling ratio for the armed harvest |
| src_done | input | 1 | Harvest completion pulse |
| src_status | input | 4 | Completion status, sampled with `src_done` |
| src_rd_req | output | 1 | Word read request |
| src_rd_idx | output | 3 | Index (0..5) of the requested word |
| src_rd_ack | input | 1 | Read acknowledge, one cycle, with data |
| src_rd_data | input | 32 | Word returned with `src_rd_ack` |
| cons_valid | output | 1 | Consumer word available |
| cons_data | output | 32 | Oldest stored word |
| cons_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Harvest in flight (pending) |
| fatal_err | output | 1 | Sticky halt after a strict continuous-test error |

## Verification
The assertions assume the source behaves in a particular way. It raises `src_done` only once per arming, and only after the arming pulse. It acknowledges only while `src_rd_req` is high, with one acknowledge per index. It never acknowledges on two back-to-back cycles. Under those assumptions, the free-space and halt checks cannot be reached by illegal input. The bench source model arms a countdown on each start pulse and acknowledges on alternate cycles while a request is open. Its status codes and zero-word positions come from a per-harvest plan, so the stimulus stays inside these assumptions.

// File: rtl/erf_pkg.sv
`timescale 1ns/1ps
package erf_pkg;
  // completion status bit positions
  localparam int ST_VALID    = 0;
  localparam int ST_AUTOCORR = 1;
  localparam int ST_WDOG     = 2;
  localparam int ST_CONT     = 3;
  localparam int STATUS_W    = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARM,
    SQ_WAIT,
    SQ_READ,
    SQ_EVAL,
    SQ_FALL,
    SQ_HALT
  } seq_state_e;
endpackage

// File: rtl/erf_ring.sv
`timescale 1ns/1ps
module erf_ring #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              hold,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic              pop,
  output logic [CNT_W-1:0]  free_cnt
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;

  assign rd_valid = (count != '0) && !hold;
  assign rd_data  = mem[tail];
  assign pop      = rd_valid && rd_ready;
  // one slot stays unused so head == tail only when empty
  assign free_cnt = CNT_W'(DEPTH - 1) - count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[head] <= wr_data;
  end

  // pointers wrap by width; DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (wr_en) head <= head + 1'b1;
      if (pop)   tail <= tail + 1'b1;
      case ({wr_en, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count != CNT_W'(DEPTH - 1)));

  assert_hold_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (hold || (rd_valid && $stable(rd_data))));
endmodule

// File: rtl/erf_osc_pick.sv
`timescale 1ns/1ps
module erf_osc_pick #(
  parameter int NUM_OSC     = 4,
  parameter int RATIO_W     = 16,
  parameter bit ABOVE_ONLY  = 1'b0,
  localparam int OSC_W      = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic [NUM_OSC*RATIO_W-1:0] ratios,
  input  logic [OSC_W-1:0]           from_idx,
  output logic                       found,
  output logic [OSC_W-1:0]           pick_idx
);
  logic [NUM_OSC-1:0] eligible;

  for (genvar gi = 0; gi < NUM_OSC; gi++) begin : g_elig
    logic usable;
    assign usable = (ratios[gi*RATIO_W +: RATIO_W] != '0);
    if (ABOVE_ONLY) begin : g_above
      assign eligible[gi] = usable && (OSC_W'(gi) > from_idx);
    end else begin : g_from
      assign eligible[gi] = usable && (OSC_W'(gi) >= from_idx);
    end
  end

  // lowest eligible index wins
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = NUM_OSC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found    = 1'b1;
        pick_idx = OSC_W'(i);
      end
    end
  end
endmodule

// File: rtl/erf_seq.sv
`timescale 1ns/1ps
module erf_seq
  import erf_pkg::*;
#(
  parameter int BATCH  = 6,
  parameter int CNT_W  = 6,
  parameter int OSC_W  = 2,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(BATCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strict_mode,
  input  logic                src_done,
  input  logic [STATUS_W-1:0] src_status,
  input  logic                src_rd_ack,
  input  logic [WORD_W-1:0]   src_rd_data,
  input  logic [CNT_W-1:0]    free_cnt,
  input  logic                pop,
  input  logic                first_found,
  input  logic [OSC_W-1:0]    first_idx,
  input  logic                next_found,
  input  logic [OSC_W-1:0]    next_idx,
  output logic                src_start,
  output logic                src_rd_req,
  output logic [IDX_W-1:0]    src_rd_idx,
  output logic [OSC_W-1:0]    active_osc,
  output logic                wr_en,
  output logic [WORD_W-1:0]   wr_data,
  output logic                busy,
  output logic                fatal_err
);
  seq_state_e       state;
  logic             kick;
  logic [IDX_W-1:0] rd_idx;
  logic [OSC_W-1:0] active;
  logic             room, bad_done, halt_done;

  assign room      = (free_cnt >= CNT_W'(BATCH));
  assign halt_done = src_status[ST_CONT] && strict_mode;
  assign bad_done  = !src_status[ST_VALID] &&
                     (src_status[ST_AUTOCORR] || src_status[ST_WDOG]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      kick   <= 1'b1;
      active <= '0;
      rd_idx <= '0;
    end else begin
      kick <= 1'b0;
      case (state)
        SQ_IDLE: begin
          kick <= pop;
          if (kick && room && first_found) begin
            active <= first_idx;
            state  <= SQ_ARM;
          end
        end
        SQ_ARM: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (src_done) begin
            if (halt_done)     state <= SQ_HALT;
            else if (bad_done) state <= SQ_FALL;
            else begin
              rd_idx <= '0;
              state  <= SQ_READ;
            end
          end
        end
        SQ_READ: begin
          if (src_rd_ack) begin
            if (src_rd_data == '0)                state <= SQ_FALL;
            else if (rd_idx == IDX_W'(BATCH - 1)) state <= SQ_EVAL;
            else                                  rd_idx <= rd_idx + 1'b1;
          end
        end
        SQ_EVAL: state <= room ? SQ_ARM : SQ_IDLE;
        SQ_FALL: begin
          if (room && next_found) begin
            active <= next_idx;
            state  <= SQ_ARM;
          end else begin
            state <= SQ_IDLE;
          end
        end
        SQ_HALT: state <= SQ_HALT;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign src_start  = (state == SQ_ARM);
  assign src_rd_req = (state == SQ_READ);
  assign src_rd_idx = rd_idx;
  assign active_osc = active;
  assign wr_en      = src_rd_req && src_rd_ack && (src_rd_data != '0);
  assign wr_data    = src_rd_data;
  assign busy       = (state != SQ_IDLE) && (state != SQ_HALT);
  assign fatal_err  = (state == SQ_HALT);

  assert_start_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_start |-> (free_cnt >= CNT_W'(BATCH)));

  assert_fatal_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err);

  assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> (!src_start && !src_rd_req));

  assert_fallback_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_FALL && room && next_found) |=> (active_osc > $past(active_osc)));

  assert_read_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_req |-> (src_rd_idx < IDX_W'(BATCH)));

  assert_one_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_start |=> (!src_start && busy));
endmodule

// File: rtl/entropy_refill_seq.sv
`timescale 1ns/1ps
module entropy_refill_seq
  import erf_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int BATCH   = 6,
  parameter int NUM_OSC = 4,
  parameter int RATIO_W = 16,
  parameter int WORD_W  = 32,
  localparam int OSC_W  = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1,
  localparam int IDX_W  = $clog2(BATCH),
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strict_mode,
  input  logic [NUM_OSC*RATIO_W-1:0] osc_ratio,
  output logic                       src_start,
  output logic [OSC_W-1:0]           src_osc_sel,
  output logic [RATIO_W-1:0]         src_ratio,
  input  logic                       src_done,
  input  logic [STATUS_W-1:0]        src_status,
  output logic                       src_rd_req,
  output logic [IDX_W-1:0]           src_rd_idx,
  input  logic                       src_rd_ack,
  input  logic [WORD_W-1:0]          src_rd_data,
  output logic                       cons_valid,
  output logic [WORD_W-1:0]          cons_data,
  input  logic                       cons_ready,
  output logic                       busy,
  output logic                       fatal_err
);
  logic              wr_en, pop;
  logic [WORD_W-1:0] wr_data;
  logic [CNT_W-1:0]  free_cnt;
  logic              first_found, next_found;
  logic [OSC_W-1:0]  first_idx, next_idx, active_osc;

  erf_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hold(fatal_err), .rd_valid(cons_valid), .rd_data(cons_data),
    .rd_ready(cons_ready), .pop(pop), .free_cnt(free_cnt)
  );

  erf_osc_pick #(.NUM_OSC(NUM_OSC), .RATIO_W(RATIO_W), .ABOVE_ONLY(1'b0)) u_first (
    .ratios(osc_ratio), .from_idx('0), .found(first_found), .pick_idx(first_idx)
  );

  erf_osc_pick #(.NUM_OSC(NUM_OSC), .RATIO_W(RATIO_W), .ABOVE_ONLY(1'b1)) u_next (
    .ratios(osc_ratio), .from_idx(active_osc), .found(next_found), .pick_idx(next_idx)
  );

  erf_seq #(.BATCH(BATCH), .CNT_W(CNT_W), .OSC_W(OSC_W), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .src_done(src_done), .src_status(src_status),
    .src_rd_ack(src_rd_ack), .src_rd_data(src_rd_data),
    .free_cnt(free_cnt), .pop(pop),
    .first_found(first_found), .first_idx(first_idx),
    .next_found(next_found), .next_idx(next_idx),
    .src_start(src_start), .src_rd_req(src_rd_req), .src_rd_idx(src_rd_idx),
    .active_osc(active_osc), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .fatal_err(fatal_err)
  );

  assign src_osc_sel = active_osc;
  assign src_ratio   = osc_ratio[active_osc*RATIO_W +: RATIO_W];

  assert_ratio_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_start |-> (src_ratio != '0));
endmodule

// File: tb/tb_entropy_refill_seq.sv
`timescale 1ns/1ps
module tb_entropy_refill_seq;
  localparam int BATCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_mode = 1'b0;
  logic [63:0] osc_ratio = {16'd40, 16'd30, 16'd0, 16'd10};
  logic        src_start;
  logic [1:0]  src_osc_sel;
  logic [15:0] src_ratio;
  logic        src_done = 1'b0;
  logic [3:0]  src_status = '0;
  logic        src_rd_req;
  logic [2:0]  src_rd_idx;
  logic        src_rd_ack = 1'b0;
  logic [31:0] src_rd_data = '0;
  logic        cons_valid;
  logic [31:0] cons_data;
  logic        cons_ready = 1'b0;
  logic        busy, fatal_err;

  always #2.5 clk = ~clk;

  entropy_refill_seq dut (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode), .osc_ratio(osc_ratio),
    .src_start(src_start), .src_osc_sel(src_osc_sel), .src_ratio(src_ratio),
    .src_done(src_done), .src_status(src_status),
    .src_rd_req(src_rd_req), .src_rd_idx(src_rd_idx),
    .src_rd_ack(src_rd_ack), .src_rd_data(src_rd_data),
    .cons_valid(cons_valid), .cons_data(cons_data), .cons_ready(cons_ready),
    .busy(busy), .fatal_err(fatal_err)
  );

  int checks = 0;
  int fails = 0;
  int pop_budget = 0;
  int plan_osc[$];
  int plan_zero[$];
  logic [3:0] plan_stat[$];
  logic [31:0] exp_q[$];
  int plan_k = 0;
  int start_k = 0;
  int delay = 0;
  int cur_k = 0;
  int cur_zero = 6;
  logic [3:0] cur_stat = '0;
  bit cur_err = 1'b0;

  function automatic logic [31:0] word_val(int k, int i);
    return 32'h5A00_0000 | (32'(k) << 8) | 32'(i + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: plans one harvest and pushes the words it must yield
  task automatic plan_harvest(input int osc, input logic [3:0] st, input int zero_at);
    bit dropped;
    plan_osc.push_back(osc);
    plan_stat.push_back(st);
    plan_zero.push_back(zero_at);
    dropped = (st[3] && strict_mode) || (!st[0] && (st[1] || st[2]));
    if (!dropped)
      for (int i = 0; i < zero_at && i < BATCH; i++) exp_q.push_back(word_val(plan_k, i));
    plan_k++;
  endtask

  task automatic pop_n(input int n);
    @(posedge clk);
    pop_budget = pop_budget + n;
    while (pop_budget > 0) @(negedge clk);
  endtask

  task automatic wait_quiet();
    int q;
    repeat (4) @(negedge clk);
    q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural entropy source
  always @(negedge clk) begin
    src_done = 1'b0;
    if (rst_n) begin
      if (src_start) begin
        chk(delay == 0, "R11 start while harvest outstanding", 32'(delay), 0);
        if (plan_osc.size() == 0) begin
          chk(1'b0, "R11 unexpected start", 32'(src_osc_sel), 0);
        end else begin
          int eo;
          eo = plan_osc.pop_front();
          cur_stat = plan_stat.pop_front();
          cur_zero = plan_zero.pop_front();
          chk(src_osc_sel == eo[1:0], "R4 R5 R6 oscillator index", 32'(src_osc_sel), 32'(eo));
          chk(src_ratio == osc_ratio[eo*16 +: 16], "R4 ratio", 32'(src_ratio), 32'(osc_ratio[eo*16 +: 16]));
          cur_err = !cur_stat[0] && (cur_stat[1] || cur_stat[2]);
          cur_k = start_k;
          start_k++;
          delay = 3;
        end
      end else if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          src_done = 1'b1;
          src_status = cur_stat;
        end
      end
      if (src_rd_req && !src_rd_ack) begin
        if (cur_err) chk(1'b0, "R6 read after failed completion", 32'(src_rd_idx), 0);
        src_rd_ack = 1'b1;
        src_rd_data = (int'(src_rd_idx) == cur_zero) ? 32'h0 : word_val(cur_k, int'(src_rd_idx));
      end else begin
        src_rd_ack = 1'b0;
      end
    end
  end

  // monitor / scoreboard on the consumer port
  always @(negedge clk) begin
    cons_ready = (pop_budget > 0) && rst_n;
    if (cons_ready && cons_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 word with empty scoreboard", cons_data, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(cons_data == e, "R2 order", cons_data, e);
      end
      pop_budget--;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d0;
    for (int k = 0; k < 5; k++) plan_harvest(0, 4'b0001, 6);
    repeat (3) @(negedge clk);
    chk(!cons_valid && !busy && !fatal_err && !src_start, "R1 reset state",
        {28'b0, cons_valid, busy, fatal_err, src_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cons_valid && !fatal_err, "R1 just after reset", {30'b0, cons_valid, fatal_err}, 0);

    // initial fill, no consumer
    wait_quiet();
    chk(plan_osc.size() == 0, "R1 R3 five batches armed", 32'(plan_osc.size()), 0);
    chk(!busy, "R10 idle when room runs out", 32'(busy), 0);
    chk(cons_valid, "R2 data available", 32'(cons_valid), 1);
    d0 = cons_data;
    repeat (3) @(negedge clk);
    chk(cons_valid && cons_data == d0 && d0 == word_val(0, 0), "R2 hold without ready", cons_data, word_val(0, 0));

    // fallback chain: autocorr on 0, skip zero ratio 1, watchdog on 2, good on 3
    plan_harvest(0, 4'b0010, 6);
    plan_harvest(2, 4'b0100, 6);
    plan_harvest(3, 4'b0001, 6);
    pop_n(5);
    wait_quiet();
    chk(plan_osc.size() == 0, "R6 fallback chain armed", 32'(plan_osc.size()), 0);
    chk(!busy, "R3 idle at 31 words", 32'(busy), 0);

    // zero words and exhaustion
    plan_harvest(0, 4'b0001, 2);
    plan_harvest(2, 4'b0100, 6);
    plan_harvest(3, 4'b0001, 0);
    pop_n(11);
    wait_quiet();
    chk(plan_osc.size() == 0, "R8 zero word falls back", 32'(plan_osc.size()), 0);
    chk(!busy, "R9 idle after exhaustion", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk(!busy, "R9 no restart without a read", 32'(busy), 0);

    // von Neumann only, and non-strict continuous-test error
    plan_harvest(0, 4'b0000, 6);
    plan_harvest(0, 4'b1001, 6);
    pop_n(7);
    wait_quiet();
    chk(plan_osc.size() == 0, "R7 R9 R10 restart and re-arm", 32'(plan_osc.size()), 0);
    chk(!fatal_err, "R12 non-strict ignored", 32'(fatal_err), 0);

    // strict continuous-test error
    @(posedge clk);
    strict_mode = 1'b1;
    plan_harvest(0, 4'b1001, 6);
    pop_n(2);
    wait_quiet();
    chk(fatal_err, "R12 fatal raised", 32'(fatal_err), 1);
    chk(!cons_valid, "R12 consumer blocked", 32'(cons_valid), 0);
    chk(!busy, "R12 no activity", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk(fatal_err && !cons_valid, "R12 sticky", {30'b0, fatal_err, cons_valid}, 2);
    chk(plan_osc.size() == 0, "R11 every plan used once", 32'(plan_osc.size()), 0);
    finish_run();
  end
endmodule